// File: doc/BRIEF.md
# Control-Word Register Access Response Generator

This block decides the two-bit acknowledge pair, written {NAK,ACK}, that a serial audio bus slave drives for the register read or write command carried in each frame's control word. The frame decoder presents the decoded command: its opcode, target device address, 16-bit register address and read/write direction. It also presents the frame's parity and bus-clash findings, and the slave's attachment and enumeration state. The block combines these with an address attribute map of the local register space. It sorts every applicable condition into three classes, fail, ignored and OK, and picks the strongest class.

The address space splits into two regions. Addresses below 0x1000 are judged on the local attribute map. Addresses from 0x1000 upward go to an internal memory bridge. For those, an OK only means the bridge accepted the request and started it, and a busy bridge turns the command into a fail. The result is captured on the cycle marked as the response slot of the frame and is held until the next slot. On an accepted upper-region command the block also issues a one-cycle request to the bridge.

Top module: `ctlw_resp`

## Requirements
- R1: `resp` is {NAK,ACK}: 2'b10 fail, 2'b00 ignored, 2'b01 OK. The value 2'b11 never appears.
- R2: If conditions of several classes hold in one frame, fail beats ignored and OK, and ignored beats OK.
- R3: A parity error, or a clash reported by `clash_any` that is not exempt under R4, gives fail at any address, even for commands otherwise ignored.
- R4: A clash flagged `clash_on_shared` (only the shared PREQ/NAK/ACK bits) has no effect. A clash flagged `clash_on_data` (only group read data or slave status) has no effect when `dev_addr` is 0, 12, 13 or 15, and gives fail for any other device address.
- R5: For `reg_addr` >= 0x1000, an addressed read or write while `br_busy` is high gives fail, and no bridge request is issued.
- R6: For `reg_addr` >= 0x1000, an addressed read or write while the bridge is idle gives OK. On the cycle after the slot, `br_req` pulses once, carrying the address and direction. `br_busy` then stays high until the cycle after `br_done`.
- R7: The response is ignored when `attached` is low, when `dev_addr` differs from `my_dev`, or when the opcode is not a read or a write. Opcode 3'b010 is read, 3'b011 is write, 3'b000 is ping, and every other code is reserved.
- R8: Below 0x1000, bits [11:8] of the address select a port and bits [7:0] an offset. Port 0 has offset 0x00 read-only, 0x01–0x03 read/write, 0x04 write-only, 0x10–0x15 identity (read-only) and 0x16 device number (read/write). Data ports 1–3 have offsets 0x00–0x0F read/write and 0x10 read-only. Ports 4–14 and all other offsets are unimplemented and give ignored. So do a read of a write-only location and a write of a read-only one.
- R9: Port 15 is a group alias holding offsets 0x00–0x0F. A write there gives OK and a read gives ignored. While `enumerated` is low, a read of the identity registers and a write of the device number give ignored.
- R10: A lower-region access that breaks none of the rules in R3, R7, R8 and R9 gives OK.
- R11: `resp` changes only on the edge where `resp_slot` is high. It takes 2'b00 when `cmd_valid` is low at that edge and is 2'b00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resp_slot | input | 1 | Response slot of the current frame; captures the result |
| cmd_valid | input | 1 | A decoded command is present this frame |
| cmd_op | input | 3 | Opcode (R7 encoding) |
| dev_addr | input | 4 | Target device address of the command |
| my_dev | input | 4 | Device number of this slave |
| reg_addr | input | 16 | Register address |
| attached | input | 1 | Slave is attached to the bus |
| enumerated | input | 1 | Slave has completed enumeration |
| parity_err | input | 1 | Control-word parity mismatch |
| clash_any | input | 1 | A bus clash was seen in the control word |
| clash_on_shared | input | 1 | The clash touched only shared acknowledge/request bits |
| clash_on_data | input | 1 | The clash touched only group read data or status |
| br_done | input | 1 | Bridge finished its current access |
| resp | output | 2 | Registered {NAK,ACK} |
| br_req | output | 1 | One-cycle bridge request |
| br_addr | output | 16 | Address of the bridge request |
| br_write | output | 1 | Direction of the bridge request, 1 = write |
| br_busy | output | 1 | Bridge access outstanding |

## Verification
A wrong busy flag shows first on the next upper-region command. That command returns fail where OK was due, or OK with an extra `br_req` while a request is still open. The error is visible on the edge after that frame's slot. A fault in the attribute decode or the priority merge appears on `resp` one cycle after the slot that carries the affected address or condition mix. The bench therefore sweeps every port class, both directions and the mixed-condition frames. A register that drops its hold shows between slots as a `resp` change with no slot.

// File: rtl/ctlw_resp_pkg.sv
package ctlw_resp_pkg;
  typedef enum logic [1:0] {
    RSP_IGNORED = 2'b00,
    RSP_OK      = 2'b01,
    RSP_FAIL    = 2'b10
  } rsp_e;

  localparam logic [2:0] OP_PING  = 3'b000;
  localparam logic [2:0] OP_READ  = 3'b010;
  localparam logic [2:0] OP_WRITE = 3'b011;

  localparam int ADDR_W   = 16;
  localparam int DEV_W    = 4;
  localparam int PORT_W   = 4;
  localparam int OFF_W    = 8;

  typedef struct packed {
    logic rd_ok;
    logic wr_ok;
  } attr_t;
endpackage

// File: rtl/ctlw_attr_map.sv
module ctlw_attr_map
  import ctlw_resp_pkg::*;
#(
  parameter int N_DP    = 3,
  parameter int DP_REGS = 16
) (
  input  logic [PORT_W+OFF_W-1:0] laddr,
  input  logic                    enumerated,
  output attr_t                   attr
);
  localparam logic [PORT_W-1:0] ALIAS_PORT = '1;
  localparam logic [OFF_W-1:0]  DP_RO_OFF  = OFF_W'(DP_REGS);

  logic [PORT_W-1:0] port;
  logic [OFF_W-1:0]  off;
  logic              p0_rd, p0_wr;
  logic [N_DP-1:0]   dp_rd, dp_wr;
  logic              al_wr;

  assign port = laddr[PORT_W+OFF_W-1:OFF_W];
  assign off  = laddr[OFF_W-1:0];

  always_comb begin
    p0_rd = 1'b0;
    p0_wr = 1'b0;
    if (port == '0) begin
      unique case (off)
        8'h00:                   p0_rd = 1'b1;
        8'h01, 8'h02, 8'h03: begin
          p0_rd = 1'b1;
          p0_wr = 1'b1;
        end
        8'h04:                   p0_wr = 1'b1;
        8'h10, 8'h11, 8'h12,
        8'h13, 8'h14, 8'h15:     p0_rd = enumerated;
        8'h16: begin
          p0_rd = 1'b1;
          p0_wr = enumerated;
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_DP; g++) begin : g_dp
    localparam logic [PORT_W-1:0] PNUM = PORT_W'(g + 1);
    assign dp_wr[g] = (port == PNUM) && (off < DP_RO_OFF);
    assign dp_rd[g] = (port == PNUM) && (off <= DP_RO_OFF);
  end

  assign al_wr = (port == ALIAS_PORT) && (off < DP_RO_OFF);

  assign attr.rd_ok = p0_rd | (|dp_rd);
  assign attr.wr_ok = p0_wr | (|dp_wr) | al_wr;
endmodule

// File: rtl/ctlw_cond_eval.sv
module ctlw_cond_eval
  import ctlw_resp_pkg::*;
(
  input  logic [2:0]        cmd_op,
  input  logic [DEV_W-1:0]  dev_addr,
  input  logic [DEV_W-1:0]  my_dev,
  input  logic              upper,
  input  logic              attached,
  input  logic              parity_err,
  input  logic              clash_any,
  input  logic              clash_on_shared,
  input  logic              clash_on_data,
  input  logic              br_busy,
  input  attr_t             attr,
  output logic              is_write,
  output logic              cond_fail,
  output logic              cond_ign
);
  logic is_rw, addressed, shared_dev, clash_fail, loc_deny;

  assign is_write   = (cmd_op == OP_WRITE);
  assign is_rw      = (cmd_op == OP_READ) || is_write;
  assign addressed  = attached && is_rw && (dev_addr == my_dev);
  assign shared_dev = (dev_addr == 4'd0) || (dev_addr == 4'd12) ||
                      (dev_addr == 4'd13) || (dev_addr == 4'd15);
  assign clash_fail = clash_any && !clash_on_shared &&
                      !(clash_on_data && shared_dev);
  assign loc_deny   = !upper && !(is_write ? attr.wr_ok : attr.rd_ok);

  assign cond_fail = parity_err || clash_fail || (upper && addressed && br_busy);
  assign cond_ign  = !addressed || loc_deny;
endmodule

// File: rtl/ctlw_bridge_track.sv
module ctlw_bridge_track (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic done,
  output logic busy
);
  logic busy_d;

  always_comb begin
    busy_d = busy;
    if (issue)      busy_d = 1'b1;
    else if (done)  busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_d;
  end
endmodule

// File: rtl/ctlw_resp.sv
module ctlw_resp
  import ctlw_resp_pkg::*;
#(
  parameter int N_DP    = 3,
  parameter int DP_REGS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        resp_slot,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [3:0]  dev_addr,
  input  logic [3:0]  my_dev,
  input  logic [15:0] reg_addr,
  input  logic        attached,
  input  logic        enumerated,
  input  logic        parity_err,
  input  logic        clash_any,
  input  logic        clash_on_shared,
  input  logic        clash_on_data,
  input  logic        br_done,
  output logic [1:0]  resp,
  output logic        br_req,
  output logic [15:0] br_addr,
  output logic        br_write,
  output logic        br_busy
);
  localparam int LOW_W = PORT_W + OFF_W;

  attr_t attr;
  logic  upper, is_write, cond_fail, cond_ign, issue;
  rsp_e  rsp_calc;
  logic [1:0]  resp_d;
  logic        req_d, wr_d;
  logic [15:0] addr_d;

  assign upper = |reg_addr[ADDR_W-1:LOW_W];

  ctlw_attr_map #(.N_DP(N_DP), .DP_REGS(DP_REGS)) u_map (
    .laddr      (reg_addr[LOW_W-1:0]),
    .enumerated (enumerated),
    .attr       (attr)
  );

  ctlw_cond_eval u_eval (
    .cmd_op          (cmd_op),
    .dev_addr        (dev_addr),
    .my_dev          (my_dev),
    .upper           (upper),
    .attached        (attached),
    .parity_err      (parity_err),
    .clash_any       (clash_any),
    .clash_on_shared (clash_on_shared),
    .clash_on_data   (clash_on_data),
    .br_busy         (br_busy),
    .attr            (attr),
    .is_write        (is_write),
    .cond_fail       (cond_fail),
    .cond_ign        (cond_ign)
  );

  always_comb begin
    if (cond_fail)     rsp_calc = RSP_FAIL;
    else if (cond_ign) rsp_calc = RSP_IGNORED;
    else               rsp_calc = RSP_OK;
  end

  assign issue = resp_slot && cmd_valid && upper && (rsp_calc == RSP_OK);

  ctlw_bridge_track u_trk (
    .clk   (clk),
    .rst_n (rst_n),
    .issue (issue),
    .done  (br_done),
    .busy  (br_busy)
  );

  always_comb begin
    resp_d = resp;
    if (resp_slot) resp_d = cmd_valid ? rsp_calc : RSP_IGNORED;
    req_d  = issue;
    addr_d = issue ? reg_addr : br_addr;
    wr_d   = issue ? is_write : br_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp     <= 2'b00;
      br_req   <= 1'b0;
      br_addr  <= '0;
      br_write <= 1'b0;
    end else begin
      resp     <= resp_d;
      br_req   <= req_d;
      br_addr  <= addr_d;
      br_write <= wr_d;
    end
  end
endmodule

// File: rtl/ctlw_resp_chk.sv
module ctlw_resp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        resp_slot,
  input logic        cmd_valid,
  input logic [15:0] reg_addr,
  input logic        parity_err,
  input logic        br_done,
  input logic [1:0]  resp,
  input logic        br_req,
  input logic        br_busy
);
  p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    resp != 2'b11);

  p_parity_fails_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_slot && cmd_valid && parity_err |=> resp == 2'b10);

  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_slot && cmd_valid && br_busy && (reg_addr[15:12] != 4'h0)
    |=> resp != 2'b01 && !br_req);

  p_req_with_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    br_req |-> resp == 2'b01 && br_busy);

  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    br_busy && !br_done |=> br_busy);

  p_hold_between_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_slot |=> $stable(resp));

  p_idle_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_slot && !cmd_valid |=> resp == 2'b00);
endmodule

bind ctlw_resp ctlw_resp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .resp_slot  (resp_slot),
  .cmd_valid  (cmd_valid),
  .reg_addr   (reg_addr),
  .parity_err (parity_err),
  .br_done    (br_done),
  .resp       (resp),
  .br_req     (br_req),
  .br_busy    (br_busy)
);

// File: tb/ctlw_resp_bench.sv
`timescale 1ns/1ps
module ctlw_resp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        resp_slot = 0, cmd_valid = 0;
  logic [2:0]  cmd_op = 0;
  logic [3:0]  dev_addr = 0, my_dev = 4'd5;
  logic [15:0] reg_addr = 0;
  logic        attached = 1, enumerated = 1;
  logic        parity_err = 0, clash_any = 0, clash_on_shared = 0, clash_on_data = 0;
  logic        br_done = 0;
  logic [1:0]  resp;
  logic        br_req, br_write, br_busy;
  logic [15:0] br_addr;

  always #4 clk = ~clk;

  ctlw_resp u_ctlw_resp (.*);

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R11";
  logic [1:0]  m_resp = 0;
  logic        m_req = 0, m_busy = 0, m_wr = 0;
  logic [15:0] m_addr = 0;
  bit finished = 0;

  function automatic logic [1:0] model();
    bit rw, hit, rd, wr, fail, ign;
    int port, off;
    rw   = (cmd_op == 3'b010) || (cmd_op == 3'b011);
    hit  = attached && rw && (dev_addr == my_dev);
    fail = parity_err;
    if (clash_any && !clash_on_shared &&
        !(clash_on_data && (dev_addr inside {0, 12, 13, 15}))) fail = 1;
    ign = !hit;
    if (reg_addr >= 16'h1000) begin
      if (hit && m_busy) fail = 1;
    end else begin
      port = reg_addr[11:8]; off = reg_addr[7:0];
      rd = 0; wr = 0;
      if (port == 0) begin
        if (off == 0) rd = 1;
        else if (off >= 1 && off <= 3) begin rd = 1; wr = 1; end
        else if (off == 4) wr = 1;
        else if (off >= 16 && off <= 21) rd = enumerated;
        else if (off == 22) begin rd = 1; wr = enumerated; end
      end else if (port >= 1 && port <= 3) begin
        wr = off < 16; rd = off <= 16;
      end else if (port == 15) wr = off < 16;
      if (cmd_op == 3'b011 ? !wr : !rd) ign = 1;
    end
    if (fail) return 2'b10;
    if (ign)  return 2'b00;
    return 2'b01;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_resp <= 0; m_req <= 0; m_busy <= 0;
    end else begin
      logic [1:0] r;
      r = model();
      m_req <= 0;
      if (resp_slot) begin
        m_resp <= cmd_valid ? r : 2'b00;
        if (cmd_valid && r == 2'b01 && reg_addr >= 16'h1000) begin
          m_req <= 1; m_busy <= 1; m_addr <= reg_addr; m_wr <= (cmd_op == 3'b011);
        end else if (br_done) m_busy <= 0;
      end else if (br_done) m_busy <= 0;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (resp !== m_resp || br_req !== m_req || br_busy !== m_busy ||
          (m_req && (br_addr !== m_addr || br_write !== m_wr))) begin
        fails++;
        $display("FAIL %s t=%0t resp=%b req=%b busy=%b addr=%h wr=%b exp resp=%b req=%b busy=%b addr=%h wr=%b",
                 tag, $time, resp, br_req, br_busy, br_addr, br_write,
                 m_resp, m_req, m_busy, m_addr, m_wr);
      end
    end
  end

  task automatic frame(input string t, input logic v, input logic [2:0] op,
                       input logic [3:0] dv, input logic [15:0] a,
                       input logic pe = 0, input logic ca = 0,
                       input logic cs = 0, input logic cd = 0);
    @(negedge clk); #1;
    tag = t; resp_slot = 1; cmd_valid = v; cmd_op = op; dev_addr = dv;
    reg_addr = a; parity_err = pe; clash_any = ca; clash_on_shared = cs; clash_on_data = cd;
    @(negedge clk); #1;
    resp_slot = 0; parity_err = 0; clash_any = 0; clash_on_shared = 0; clash_on_data = 0;
    cmd_op = 3'b101; reg_addr = 16'h0FFF;
    repeat (2) @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk); #1; tag = "R6"; br_done = 1;
    @(negedge clk); #1; br_done = 0;
  endtask

  localparam logic [2:0] RD = 3'b010, WR = 3'b011;

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R10 lower region OK
    frame("R10", 1, RD, 5, 16'h0001);
    frame("R10", 1, WR, 5, 16'h020F);
    frame("R10", 1, RD, 5, 16'h0310);
    // R8 ignored locations
    frame("R8", 1, WR, 5, 16'h0000);
    frame("R8", 1, RD, 5, 16'h0004);
    frame("R8", 1, WR, 5, 16'h0310);
    frame("R8", 1, RD, 5, 16'h0405);
    frame("R8", 1, WR, 5, 16'h0E00);
    frame("R8", 1, RD, 5, 16'h0030);
    // R9 alias and enumeration
    frame("R9", 1, WR, 5, 16'h0F03);
    frame("R9", 1, RD, 5, 16'h0F03);
    frame("R9", 1, RD, 5, 16'h0012);
    frame("R9", 1, WR, 5, 16'h0016);
    enumerated = 0;
    frame("R9", 1, RD, 5, 16'h0012);
    frame("R9", 1, WR, 5, 16'h0016);
    frame("R9", 1, RD, 5, 16'h0016);
    enumerated = 1;
    // R7 ignored commands
    frame("R7", 1, 3'b000, 5, 16'h0001);
    frame("R7", 1, 3'b110, 5, 16'h0001);
    frame("R7", 1, RD, 6, 16'h0001);
    attached = 0;
    frame("R7", 1, RD, 5, 16'h0001);
    attached = 1;
    // R3 / R2 fail priority
    frame("R3", 1, RD, 5, 16'h0001, 1);
    frame("R2", 1, RD, 7, 16'h0405, 1);
    frame("R3", 1, WR, 5, 16'h2000, 0, 1);
    // R4 clash exemptions
    frame("R4", 1, RD, 5, 16'h0001, 0, 1, 1, 0);
    frame("R4", 1, RD, 12, 16'h0001, 0, 1, 0, 1);
    frame("R4", 1, RD, 0, 16'h0001, 0, 1, 0, 1);
    frame("R4", 1, RD, 5, 16'h0001, 0, 1, 0, 1);
    // R6 / R5 bridge region
    frame("R6", 1, WR, 5, 16'h1234);
    frame("R5", 1, RD, 5, 16'hFFFF);
    frame("R2", 1, RD, 9, 16'h8000);
    done_pulse();
    repeat (2) @(negedge clk);
    frame("R6", 1, RD, 5, 16'hFFFF);
    done_pulse();
    frame("R6", 1, RD, 5, 16'h1000);
    done_pulse();
    // R11 idle frame and hold
    frame("R11", 0, RD, 5, 16'h0001);
    frame("R1", 1, RD, 5, 16'h0001);
    repeat (5) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired: act=hung exp=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule